// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is an 8-bit down-counting interval timer on a small synchronous register port. It advances once per system clock. A write to a timer address loads a start value and picks one of four prescale ratios from the low two address bits. From then on the count drops by one every prescale period.

When the count goes below zero, the timer sets a sticky expiry flag, shows 0xFF and starts counting down on every clock. It stays in this fast mode until software reads the count back. That read also returns the timer to the selected ratio and clears the flag. The one exception is a read in the same clock as the wrap: the flag then stays set.

A status address returns the expiry flag in its top bit. The flag is also driven out directly as a level for the surrounding interrupt logic.

Top module: `ivl_timer`

## Requirements
- R1: After reset the flag is low, a status read returns 0x00 and the count is 0x00. The ratio is 1024 and the prescaler phase is 0. With no write, the flag therefore rises at the 1024th clock edge after reset is released, and the count then shows 0xFF and falls by one per edge.
- R2: A write with cs=1, we=1, addr[2]=1 and addr[4]=1 is a timer write:
  - it loads wdata into the count, clears the flag and leaves fast mode;
  - addr[1:0] selects the ratio: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 1024 clocks per step.
- R3: After a timer write with value V and ratio r, the first step happens at the next edge and then every r edges. k edges after the write (k >= 1) the count is V - (floor((k-1)/r) + 1), for as long as that is not negative.
- R4: The step that would take the count below zero happens at edge V*r + 1. It sets the count to 0xFF, raises the flag and enters fast mode.
- R5: In fast mode the count falls by one on every edge and wraps modulo 256.
- R6: A count read is cs=1, we=0, addr[2]=1 and addr[0]=0 (addresses 4 and 6). It returns, one edge later on rdata, the count as updated at that edge. It always leaves fast mode, so the ratio steps resume.
- R7: A count read clears the flag, except when the wrap occurs at the same edge as the read; then the flag stays set.
- R8: A status read is cs=1, we=0, addr[2]=1 and addr[0]=1. It returns the flag in bit 7 with bits 6..0 zero, and it does not change the flag.
- R9: Neither of these affects the timer:
  - a write with addr[2]=1 and addr[4]=0;
  - any access with addr[2]=0.
  A read with addr[2]=0 returns 0x00.
- R10: The prescaler runs freely through fast mode and reads. After a read ends fast mode, the next step falls on an edge k with (k-1) mod r = 0, counted from the last timer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one timer cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select for the register port |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_flag | output | 1 | Sticky expiry flag |

## Verification
The bench goes after the following corner cases:
- **Step phase after a write.** The first step must land on the very next edge and the rest r edges apart, or every count read before expiry is off by one.
- **Expiry edge.** The wrap must happen exactly at edge V*r + 1, and fast mode must then take a step on each edge. A design that keeps the ratio after the wrap would return a count near 0xFF long after it should have fallen.
- **Read at the wrap edge.** A read on that edge must keep the flag set. A design that lets the read clear the flag there would leave the expiry unseen.
- **Prescaler phase across fast mode.** The phase must keep running. A design that restarts the phase when the read ends fast mode would take its next step on the wrong edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int unsigned NUM_SEL  = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_SEL);
  localparam int unsigned SHIFT_TAB [NUM_SEL] = '{0, 3, 6, 10};
  localparam int unsigned PRE_W    = 10;
  localparam int unsigned BIT_STAT = 0;
  localparam int unsigned BIT_IO   = 2;
  localparam int unsigned BIT_TMR  = 4;
endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler
  import ivl_timer_pkg::*;
#(
  parameter int unsigned PW = PRE_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int unsigned NSEL = 1 << SW;

  logic [PW-1:0] lim_tab [NSEL];
  logic [SW-1:0] sel_q;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] lim_cur;

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    assign lim_tab[i] = PW'((64'(1) << SHIFT_TAB[i]) - 64'(1));
  end

  assign lim_cur = lim_tab[sel_q];
  assign tick    = (phase_q == lim_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SW'(NSEL - 1);
      phase_q <= '0;
    end else if (load) begin
      sel_q   <= sel;
      phase_q <= lim_tab[sel];
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ivl_downcount.sv
module ivl_downcount #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          rd_cnt,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_upd,
  output logic          flag_q,
  output logic          flag_upd,
  output logic          fast_q
);
  logic step;
  logic wrap;
  logic fast_upd;

  assign step     = fast_q | tick;
  assign wrap     = ~fast_q & tick & (cnt_q == '0);
  assign cnt_upd  = step ? cnt_q - 1'b1 : cnt_q;
  assign flag_upd = flag_q | wrap;
  assign fast_upd = fast_q | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      flag_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (rd_cnt) begin
      cnt_q  <= cnt_upd;
      flag_q <= wrap;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_upd;
      flag_q <= flag_upd;
      fast_q <= fast_upd;
    end
  end
endmodule

// File: rtl/ivl_regdec.sv
module ivl_regdec
  import ivl_timer_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cnt_upd,
  input  logic          flag_upd,
  output logic          load,
  output logic [SW-1:0] sel,
  output logic          rd_cnt,
  output logic [DW-1:0] rdata
);
  logic io_hit;
  logic rd_stat;
  logic rd_other;
  logic unused_addr;

  assign unused_addr = ^addr;
  assign io_hit   = cs & addr[BIT_IO];
  assign load     = io_hit & we & addr[BIT_TMR];
  assign sel      = addr[SW-1:0];
  assign rd_cnt   = io_hit & ~we & ~addr[BIT_STAT];
  assign rd_stat  = io_hit & ~we & addr[BIT_STAT];
  assign rd_other = cs & ~we & ~addr[BIT_IO];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_cnt) begin
      rdata <= DW'(cnt_upd);
    end else if (rd_stat) begin
      rdata         <= '0;
      rdata[DW-1]   <= flag_upd;
    end else if (rd_other) begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_flag
);
  logic             load;
  logic [SEL_W-1:0] sel;
  logic             rd_cnt;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_upd;
  logic             flag_q;
  logic             flag_upd;
  logic             fast_q;

  ivl_regdec #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .SW(SEL_W)) u_dec (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .cnt_upd(cnt_upd), .flag_upd(flag_upd),
    .load(load), .sel(sel), .rd_cnt(rd_cnt), .rdata(rdata)
  );

  ivl_prescaler #(.PW(PRE_W), .SW(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .load(load), .sel(sel), .tick(tick)
  );

  ivl_downcount #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .load_val(wdata[CNT_W-1:0]), .rd_cnt(rd_cnt),
    .cnt_q(cnt_q), .cnt_upd(cnt_upd), .flag_q(flag_q),
    .flag_upd(flag_upd), .fast_q(fast_q)
  );

  assign irq_flag = flag_q;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              fast_q,
  input logic              load,
  input logic              rd_cnt
);
  // R2
  load_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !irq_flag);

  // R4
  rise_shows_ff_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> cnt_q == {CNT_W{1'b1}});

  // R5
  fast_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_q && !load && !rd_cnt) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[BIT_IO] && !addr[BIT_STAT]) |=> (!irq_flag || rdata == {DATA_W{1'b1}}));

  // R8
  stat_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[BIT_IO] && addr[BIT_STAT]) |=> rdata[DATA_W-2:0] == '0);

  // R9
  other_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && !addr[BIT_IO]) |=> rdata == '0);
endmodule

bind ivl_timer ivl_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
  .irq_flag(irq_flag), .cnt_q(cnt_q), .fast_q(fast_q), .load(load), .rd_cnt(rd_cnt)
);

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_flag;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  logic [7:0] rv;

  ivl_timer u0 (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_flag(irq_flag)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ecnt(input int v, input int r, input int kk);
    int kw;
    kw = v * r + 1;
    if (kk == 0) return 8'(v);
    if (kk < kw) return 8'(v - ((kk - 1) / r + 1));
    return 8'((255 - (kk - kw)) & 255);
  endfunction

  task automatic acc(input logic w, input logic [4:0] a, input logic [7:0] d);
    cs = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    rv = rdata;
    cs = 1'b0; we = 1'b0;
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    k += n;
  endtask

  task automatic twrite(input logic [1:0] s, input logic [7:0] v);
    acc(1'b1, {3'b101, s}, v);
    k = 0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    k = 0;
    chk("R1 flag after reset", {7'b0, irq_flag}, 8'h00);
    acc(1'b0, 5'b00101, 8'h00);
    chk("R1 status after reset", rv, 8'h00);
    idle(1022);
    chk("R1 no flag at edge 1023", {7'b0, irq_flag}, 8'h00);
    idle(1);
    chk("R1 flag at edge 1024", {7'b0, irq_flag}, 8'h01);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R1 count after reset wrap", rv, 8'hFE);
  endtask

  task automatic t_ratio(input logic [1:0] s, input int v);
    int r, kw, kn;
    logic [7:0] c;
    r = 1 << (s == 2'd0 ? 0 : s == 2'd1 ? 3 : s == 2'd2 ? 6 : 10);
    kw = v * r + 1;
    twrite(s, 8'(v));
    chk("R2 flag clear after write", {7'b0, irq_flag}, 8'h00);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R3 first step", rv, ecnt(v, r, k));
    idle((v * r) / 2 + 1 - k - 1);
    acc(1'b0, 5'b00110, 8'h00);
    chk("R3 mid count", rv, ecnt(v, r, k));
    idle(v * r - k - 1);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R3 last count zero", rv, 8'h00);
    idle(kw - 1 - k);
    chk("R4 no flag before wrap", {7'b0, irq_flag}, 8'h00);
    idle(1);
    chk("R4 flag at wrap", {7'b0, irq_flag}, 8'h01);
    idle(3);
    acc(1'b0, 5'b00111, 8'h00);
    chk("R8 status bit7", rv, 8'h80);
    chk("R8 status read keeps flag", {7'b0, irq_flag}, 8'h01);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R5 fast count", rv, 8'hFA);
    chk("R7 read clears flag", {7'b0, irq_flag}, 8'h00);
    c = rv;
    kn = k + 1;
    while ((kn - 1) % r != 0) kn++;
    if (kn - 1 > k) begin
      idle(kn - 1 - k - 1);
      acc(1'b0, 5'b00100, 8'h00);
      chk("R6 fast mode left", rv, c);
    end
    acc(1'b0, 5'b00100, 8'h00);
    chk("R10 step on running phase", rv, c - 8'd1);
  endtask

  task automatic t_wrap_read;
    twrite(2'b01, 8'd2);
    idle(16);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R4 read at wrap edge", rv, 8'hFF);
    chk("R7 flag kept on wrap edge read", {7'b0, irq_flag}, 8'h01);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R6 no fast step after read", rv, 8'hFF);
    chk("R7 later read clears flag", {7'b0, irq_flag}, 8'h00);
  endtask

  task automatic t_fast_wrap;
    twrite(2'b10, 8'd0);
    idle(299);
    chk("R4 flag in fast run", {7'b0, irq_flag}, 8'h01);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R5 fast wraps mod 256", rv, 8'hD4);
  endtask

  task automatic t_ignored;
    twrite(2'b01, 8'd50);
    idle(9);
    acc(1'b1, 5'b00101, 8'h07);
    acc(1'b1, 5'b10000, 8'h03);
    acc(1'b0, 5'b10000, 8'h00);
    chk("R9 read outside timer space", rv, 8'h00);
    acc(1'b0, 5'b00100, 8'h00);
    chk("R9 count unaffected", rv, ecnt(50, 8, k));
    chk("R9 flag unaffected", {7'b0, irq_flag}, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ratio(2'b00, 5);
        t_ratio(2'b01, 20);
        t_ratio(2'b10, 10);
        t_ratio(2'b11, 3);
        t_wrap_read();
        t_fast_wrap();
        t_ignored();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule